// File: doc/BRIEF.md
# DRAM Bank Read-to-Precharge Legality Tracker

This block sits beside the command scheduler of a DDR3-class memory controller and watches every command it issues (activate, read, read with auto precharge, write, precharge) together with the target bank. For each of eight banks it reports, on every clock, which command kinds may legally be issued on the next clock edge. It keeps one small state machine and a few down-counters per bank, plus one shared bus timer for the spacing between bursts. The timing values (additive latency, read and write latency, burst-to-burst spacing, read-to-precharge time, precharge time, minimum row-active time, activate-to-access time) are static configuration inputs in clock cycles.

A read that requests auto precharge puts its bank in a pending state. The block works out when the internal precharge begins. The earliest point is the additive latency plus the read-to-precharge time after the read, and never less than four clocks after the read. That point is pushed out further while the bank's minimum row-active time is still running. The precharge time is counted from the cycle in which the internal precharge actually begins. That cycle is shown as a one-cycle pulse per bank.

A command attempted while its legality flag is low is not acted upon. One cycle later the block raises a violation pulse that carries the bank and the command code.

Throughout, a command accepted at clock edge t is said to be followed by an event "k cycles later" when that event happens at edge t+k. A flag is observed as "legal at k" when it is high during the cycle that ends at edge t+k.

Top module: `dram_rdpre_tracker`

## Requirements
- R1: After reset every bank is idle. ok_act and ok_pre are all ones, ok_rd, ok_wr and ap_start are all zeros, and viol_valid is low.
- R2: An activate to an idle bank opens it, and ok_act for that bank then stays low. Read and write to that bank first become legal tRCD cycles after the activate.
- R3: After any accepted read or write, a read to any bank is legal only from tCCD cycles later. A read burst is never cut short.
- R4: After an accepted read, a write to any bank is legal only from max(tCCD, RL + tCCD + 2 - WL) cycles later.
- R5: After a read without auto precharge, a precharge to the same bank is legal only from max(4, AL + tRTP) cycles after the read. It must also be at least tRAS cycles after that bank's activate.
- R6: After a precharge, an activate to the bank is legal only from tRP cycles later. A further precharge to a precharging bank is legal, and tRP then restarts from the latest one.
- R7: For a read with auto precharge, ap_start for the bank pulses for one cycle at k = max(4, AL + tRTP, remaining tRAS since the activate). No read or write to that bank is legal afterwards until it is activated again.
- R8: After the ap_start pulse at k, an activate to that bank becomes legal at k + tRP.
- R9: An attempted command whose legality flag is low sets viol_valid for one cycle on the next cycle, with viol_bank and viol_cmd equal to the attempt. It changes no bank or bus state.
- R10: Command codes are 0 no-op, 1 activate, 2 read, 3 read with auto precharge, 4 write and 5 precharge. Codes 6 and 7 always raise a violation. A no-op never raises one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | CW | Additive latency, cycles |
| cfg_rl | input | CW | Read latency, cycles |
| cfg_wl | input | CW | Write latency, cycles |
| cfg_tccd | input | CW | Burst-to-burst spacing, cycles |
| cfg_trcd | input | CW | Activate to read/write, cycles |
| cfg_trtp | input | CW | Read to precharge, cycles |
| cfg_trp | input | CW | Precharge period, cycles |
| cfg_tras | input | CW | Minimum activate to precharge, cycles |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | Command code (R10) |
| cmd_bank | input | BW | Target bank |
| ok_act | output | NBANK | Per-bank: activate legal now |
| ok_rd | output | NBANK | Per-bank: read (either kind) legal now |
| ok_wr | output | NBANK | Per-bank: write legal now |
| ok_pre | output | NBANK | Per-bank: precharge legal now |
| ap_start | output | NBANK | Per-bank: internal auto precharge begins this cycle |
| viol_valid | output | 1 | Illegal attempt seen on the previous cycle |
| viol_bank | output | BW | Bank of that attempt |
| viol_cmd | output | 3 | Code of that attempt |

## Verification
The legality flags and ap_start are decoded from registered counters. For a command taken at edge t, a flag that is due k cycles later is high during the cycle that ends at edge t+k. The violation fields come from a register and are valid in the cycle right after the attempt. The bench drives commands on the falling edge and, after each command, samples the flags on every following falling edge, counting k from 1. It records the first k at which each flag or ap_start goes high and compares it with the value the formulas in the requirements give for sweeps of AL, tRTP, tRAS, tRP, tRCD, tCCD, RL and WL. Violation fields are sampled on the first falling edge after the attempt, and the bank flags that the attempt could have altered are read back on that same edge.

// File: rtl/rdpre_pkg.sv
package rdpre_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_RDA  = 3'd3,
      CMD_WR   = 3'd4,
      CMD_PRE  = 3'd5,
      CMD_RSV6 = 3'd6,
      CMD_RSV7 = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE   = 2'd0,
      BK_OPEN   = 2'd1,
      BK_APWAIT = 2'd2,
      BK_PRECH  = 2'd3
   } bank_st_e;

   localparam int unsigned CMD_W = 3;

endpackage

// File: rtl/rdpre_dncnt.sv
module rdpre_dncnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/rdpre_bus_timer.sv
module rdpre_bus_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_go,
   input  logic          wr_go,
   input  logic [CW-1:0] cfg_rl,
   input  logic [CW-1:0] cfg_wl,
   input  logic [CW-1:0] cfg_tccd,
   output logic          rd_ok,
   output logic          wr_ok
);
   localparam int SW = CW + 2;

   logic [SW-1:0] ccd_val;
   logic [SW-1:0] r2w_sum;
   logic [SW-1:0] r2w_val;
   logic          ccd_zero;
   logic          r2w_zero;

   always_comb begin
      ccd_val = (cfg_tccd == '0) ? '0 : SW'(cfg_tccd) - SW'(1);
      r2w_sum = SW'(cfg_rl) + SW'(cfg_tccd) + SW'(2);
      r2w_val = (r2w_sum > SW'(cfg_wl)) ? (r2w_sum - SW'(cfg_wl) - SW'(1)) : '0;
   end

   rdpre_dncnt #(.W(SW)) u_ccd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_go | wr_go),
      .load_val (ccd_val),
      .zero     (ccd_zero)
   );

   rdpre_dncnt #(.W(SW)) u_r2w (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_go),
      .load_val (r2w_val),
      .zero     (r2w_zero)
   );

   assign rd_ok = ccd_zero;
   assign wr_ok = ccd_zero & r2w_zero;
endmodule

// File: rtl/rdpre_bank.sv
module rdpre_bank
   import rdpre_pkg::*;
#(
   parameter int CW           = 6,
   parameter int RD_PRE_FLOOR = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_al,
   input  logic [CW-1:0] cfg_trcd,
   input  logic [CW-1:0] cfg_trtp,
   input  logic [CW-1:0] cfg_trp,
   input  logic [CW-1:0] cfg_tras,
   input  logic          hit,
   input  logic [2:0]    cmd,
   input  logic          bus_rd_ok,
   input  logic          bus_wr_ok,
   output logic          ok_act,
   output logic          ok_rd,
   output logic          ok_wr,
   output logic          ok_pre,
   output logic          ap_start
);
   localparam int SW = CW + 1;

   bank_st_e st_q, st_d;
   cmd_e     c;

   logic [SW-1:0] rtp_sum, rtp_span, rtp_val;
   logic [CW-1:0] rcd_val, ras_val, rp_val;
   logic          rcd_zero, ras_zero, rtp_zero, rp_zero;
   logic          is_act, is_rd, is_rda, is_pre;
   logic          ap_fire;

   assign c      = cmd_e'(cmd);
   assign is_act = hit && (c == CMD_ACT);
   assign is_rd  = hit && ((c == CMD_RD) || (c == CMD_RDA));
   assign is_rda = hit && (c == CMD_RDA);
   assign is_pre = hit && (c == CMD_PRE);

   always_comb begin
      rtp_sum  = SW'(cfg_al) + SW'(cfg_trtp);
      rtp_span = (rtp_sum > SW'(RD_PRE_FLOOR)) ? rtp_sum : SW'(RD_PRE_FLOOR);
      rtp_val  = rtp_span - SW'(1);
      rcd_val  = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;
      ras_val  = (cfg_tras == '0) ? '0 : cfg_tras - 1'b1;
      rp_val   = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;
   end

   rdpre_dncnt #(.W(CW)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(is_act), .load_val(rcd_val), .zero(rcd_zero)
   );

   rdpre_dncnt #(.W(CW)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(is_act), .load_val(ras_val), .zero(ras_zero)
   );

   rdpre_dncnt #(.W(SW)) u_rtp (
      .clk(clk), .rst_n(rst_n), .load(is_rd), .load_val(rtp_val), .zero(rtp_zero)
   );

   rdpre_dncnt #(.W(CW)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(is_pre | ap_fire), .load_val(rp_val), .zero(rp_zero)
   );

   // internal precharge begins once both the read-side and row-active windows are spent
   assign ap_fire = (st_q == BK_APWAIT) && rtp_zero && ras_zero;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         BK_IDLE: begin
            if (is_act)      st_d = BK_OPEN;
            else if (is_pre) st_d = BK_PRECH;
         end
         BK_OPEN: begin
            if (is_rda)      st_d = BK_APWAIT;
            else if (is_pre) st_d = BK_PRECH;
         end
         BK_APWAIT: begin
            if (ap_fire)     st_d = BK_PRECH;
         end
         BK_PRECH: begin
            if (is_act)       st_d = BK_OPEN;
            else if (is_pre)  st_d = BK_PRECH;
            else if (rp_zero) st_d = BK_IDLE;
         end
         default: st_d = BK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= BK_IDLE;
      else        st_q <= st_d;
   end

   assign ok_act   = (st_q == BK_IDLE) || ((st_q == BK_PRECH) && rp_zero);
   assign ok_rd    = (st_q == BK_OPEN) && rcd_zero && bus_rd_ok;
   assign ok_wr    = (st_q == BK_OPEN) && rcd_zero && bus_wr_ok;
   assign ok_pre   = ((st_q == BK_OPEN) && rtp_zero && ras_zero)
                   || (st_q == BK_IDLE) || (st_q == BK_PRECH);
   assign ap_start = ap_fire;
endmodule

// File: rtl/dram_rdpre_tracker.sv
module dram_rdpre_tracker
   import rdpre_pkg::*;
#(
   parameter  int NBANK        = 8,
   parameter  int CW           = 6,
   parameter  int RD_PRE_FLOOR = 4,
   localparam int BW           = $clog2(NBANK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    cfg_al,
   input  logic [CW-1:0]    cfg_rl,
   input  logic [CW-1:0]    cfg_wl,
   input  logic [CW-1:0]    cfg_tccd,
   input  logic [CW-1:0]    cfg_trcd,
   input  logic [CW-1:0]    cfg_trtp,
   input  logic [CW-1:0]    cfg_trp,
   input  logic [CW-1:0]    cfg_tras,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_code,
   input  logic [BW-1:0]    cmd_bank,
   output logic [NBANK-1:0] ok_act,
   output logic [NBANK-1:0] ok_rd,
   output logic [NBANK-1:0] ok_wr,
   output logic [NBANK-1:0] ok_pre,
   output logic [NBANK-1:0] ap_start,
   output logic             viol_valid,
   output logic [BW-1:0]    viol_bank,
   output logic [2:0]       viol_cmd
);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end
   if (CW < 3) begin : g_bad_cw
      $error("CW must be at least 3");
   end
   if (RD_PRE_FLOOR < 1 || RD_PRE_FLOOR >= (1 << CW)) begin : g_bad_floor
      $error("RD_PRE_FLOOR must be at least 1 and fit in CW bits");
   end

   cmd_e             c;
   logic             legal, accept, attempt_bad;
   logic [NBANK-1:0] hit;
   logic             bus_rd_ok, bus_wr_ok;
   logic             rd_go, wr_go;

   assign c = cmd_e'(cmd_code);

   always_comb begin
      unique case (c)
         CMD_NOP:          legal = 1'b1;
         CMD_ACT:          legal = ok_act[cmd_bank];
         CMD_RD, CMD_RDA:  legal = ok_rd[cmd_bank];
         CMD_WR:           legal = ok_wr[cmd_bank];
         CMD_PRE:          legal = ok_pre[cmd_bank];
         default:          legal = 1'b0;
      endcase
   end

   assign accept      = cmd_valid && legal && (c != CMD_NOP);
   assign attempt_bad = cmd_valid && !legal;
   assign rd_go       = accept && ((c == CMD_RD) || (c == CMD_RDA));
   assign wr_go       = accept && (c == CMD_WR);

   rdpre_bus_timer #(.CW(CW)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_go    (rd_go),
      .wr_go    (wr_go),
      .cfg_rl   (cfg_rl),
      .cfg_wl   (cfg_wl),
      .cfg_tccd (cfg_tccd),
      .rd_ok    (bus_rd_ok),
      .wr_ok    (bus_wr_ok)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign hit[b] = accept && (cmd_bank == BW'(b));

      rdpre_bank #(.CW(CW), .RD_PRE_FLOOR(RD_PRE_FLOOR)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_al    (cfg_al),
         .cfg_trcd  (cfg_trcd),
         .cfg_trtp  (cfg_trtp),
         .cfg_trp   (cfg_trp),
         .cfg_tras  (cfg_tras),
         .hit       (hit[b]),
         .cmd       (cmd_code),
         .bus_rd_ok (bus_rd_ok),
         .bus_wr_ok (bus_wr_ok),
         .ok_act    (ok_act[b]),
         .ok_rd     (ok_rd[b]),
         .ok_wr     (ok_wr[b]),
         .ok_pre    (ok_pre[b]),
         .ap_start  (ap_start[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_valid <= 1'b0;
         viol_bank  <= '0;
         viol_cmd   <= '0;
      end else begin
         viol_valid <= attempt_bad;
         if (attempt_bad) begin
            viol_bank <= cmd_bank;
            viol_cmd  <= cmd_code;
         end
      end
   end
endmodule

// File: rtl/rdpre_checker.sv
module rdpre_checker #(
   parameter  int NBANK        = 8,
   parameter  int CW           = 6,
   parameter  int RD_PRE_FLOOR = 4,
   localparam int BW           = $clog2(NBANK)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CW-1:0]    cfg_tccd,
   input logic [CW-1:0]    cfg_trp,
   input logic             cmd_valid,
   input logic [2:0]       cmd_code,
   input logic [BW-1:0]    cmd_bank,
   input logic [NBANK-1:0] ok_act,
   input logic [NBANK-1:0] ok_rd,
   input logic [NBANK-1:0] ok_wr,
   input logic [NBANK-1:0] ok_pre,
   input logic [NBANK-1:0] ap_start,
   input logic             viol_valid,
   input logic [BW-1:0]    viol_bank,
   input logic [2:0]       viol_cmd
);
   logic took_rd, took_pre, bad_act;

   assign took_rd  = cmd_valid && ((cmd_code == 3'd2) || (cmd_code == 3'd3)) && ok_rd[cmd_bank];
   assign took_pre = cmd_valid && (cmd_code == 3'd5) && ok_pre[cmd_bank];
   assign bad_act  = cmd_valid && (cmd_code == 3'd1) && !ok_act[cmd_bank];

   AST_OPEN_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ok_rd | ok_wr) & ok_act) == '0); // R2

   AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (took_rd && cfg_tccd > 1) |=> (ok_rd == '0 && ok_wr == '0)); // R3

   AST_RD_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (took_rd && RD_PRE_FLOOR > 1) |=> !ok_pre[$past(cmd_bank)]); // R5

   AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (took_pre && cfg_trp > 1) |=> !ok_act[$past(cmd_bank)]); // R6

   AST_AP_BLOCKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_start & (ok_act | ok_rd | ok_wr | ok_pre)) == '0); // R7

   AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(cmd_valid)); // R9

   AST_BAD_ACT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      bad_act |=> (viol_valid && viol_cmd == 3'd1 && viol_bank == $past(cmd_bank))); // R9

   AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code > 3'd5) |=> viol_valid); // R10
endmodule

bind dram_rdpre_tracker rdpre_checker #(
   .NBANK(NBANK), .CW(CW), .RD_PRE_FLOOR(RD_PRE_FLOOR)
) u_chk (.*);

// File: tb/dram_rdpre_tracker_tb.sv
`timescale 1ns/1ps
module dram_rdpre_tracker_tb;
   localparam int NB = 8;
   localparam int CW = 6;
   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_al, cfg_rl, cfg_wl, cfg_tccd, cfg_trcd, cfg_trtp, cfg_trp, cfg_tras;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = 3'd0;
   logic [BW-1:0] cmd_bank = '0;
   logic [NB-1:0] ok_act, ok_rd, ok_wr, ok_pre, ap_start;
   logic          viol_valid;
   logic [BW-1:0] viol_bank;
   logic [2:0]    viol_cmd;

   int total = 0;
   int bad   = 0;
   int fk_act, fk_rd, fk_wr, fk_pre, fk_ap;

   always #2 clk = ~clk;

   dram_rdpre_tracker #(.NBANK(NB), .CW(CW)) u_dut (.*);

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      cmd_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic issue(input int code, input int bank);
      cmd_valid = 1'b1;
      cmd_code  = 3'(code);
      cmd_bank  = BW'(bank);
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 3'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch(input int b, input int maxk);
      fk_act = -1; fk_rd = -1; fk_wr = -1; fk_pre = -1; fk_ap = -1;
      for (int k = 1; k <= maxk; k++) begin
         if (fk_act < 0 && ok_act[b])   fk_act = k;
         if (fk_rd  < 0 && ok_rd[b])    fk_rd  = k;
         if (fk_wr  < 0 && ok_wr[b])    fk_wr  = k;
         if (fk_pre < 0 && ok_pre[b])   fk_pre = k;
         if (fk_ap  < 0 && ap_start[b]) fk_ap  = k;
         if (k < maxk) @(negedge clk);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   initial begin
      #(4 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cfg_al = 0; cfg_rl = 6; cfg_wl = 5; cfg_tccd = 4;
      cfg_trcd = 3; cfg_trtp = 4; cfg_trp = 3; cfg_tras = 4;

      // R1 reset state
      do_reset();
      check("R1", "ok_act",     int'(ok_act),   255);
      check("R1", "ok_pre",     int'(ok_pre),   255);
      check("R1", "ok_rd",      int'(ok_rd),    0);
      check("R1", "ok_wr",      int'(ok_wr),    0);
      check("R1", "ap_start",   int'(ap_start), 0);
      check("R1", "viol_valid", int'(viol_valid), 0);

      // R2 activate-to-access sweep
      for (int trcd = 1; trcd <= 5; trcd++) begin
         cfg_trcd = CW'(trcd);
         do_reset();
         issue(1, trcd % NB);
         watch(trcd % NB, 12);
         check("R2", "first rd legal", fk_rd, trcd);
         check("R2", "first wr legal", fk_wr, trcd);
         check("R2", "act on open bank", fk_act, -1);
      end

      // R3 / R4 cross-bank burst spacing sweep
      cfg_trcd = 2;
      for (int tccd = 1; tccd <= 4; tccd++)
         for (int rl = 5; rl <= 7; rl++)
            for (int wl = 5; wl <= 6; wl++) begin
               cfg_tccd = CW'(tccd); cfg_rl = CW'(rl); cfg_wl = CW'(wl);
               do_reset();
               issue(1, 0);
               issue(1, 1);
               idle(3);
               issue(2, 0);
               watch(1, 20);
               check("R3", "rd after rd other bank", fk_rd, tccd);
               check("R4", "wr after rd other bank", fk_wr, imax(tccd, rl + tccd + 2 - wl));
            end

      // R5 / R7 / R8 read-to-precharge and auto precharge sweep (read 3 cycles after activate)
      cfg_trcd = 3; cfg_tccd = 4; cfg_rl = 6; cfg_wl = 5;
      for (int al = 0; al <= 2; al++)
         for (int trtp = 2; trtp <= 5; trtp++)
            for (int ti = 0; ti <= 4; ti++)
               for (int mode = 0; mode <= 1; mode++) begin
                  int tras, trp, gate;
                  tras = 4 + 3 * ti;
                  trp  = 1 + ((al + trtp + ti) % 3);
                  gate = imax(imax(4, al + trtp), tras - 3);
                  cfg_al = CW'(al); cfg_trtp = CW'(trtp); cfg_tras = CW'(tras); cfg_trp = CW'(trp);
                  do_reset();
                  issue(1, 2);
                  idle(2);
                  issue((mode == 0) ? 2 : 3, 2);
                  watch(2, 50);
                  if (mode == 0) begin
                     check("R5", "first pre legal after rd", fk_pre, gate);
                     check("R5", "no auto precharge", fk_ap, -1);
                  end else begin
                     check("R7", "auto precharge start", fk_ap, gate);
                     check("R7", "rd blocked after rda", fk_rd, -1);
                     check("R8", "act after auto precharge", fk_act, gate + trp);
                  end
               end

      // R6 precharge-to-activate, single and repeated precharge
      cfg_al = 0; cfg_trtp = 4; cfg_tras = 4; cfg_trcd = 3;
      for (int trp = 1; trp <= 5; trp++)
         for (int rep = 0; rep <= 1; rep++) begin
            cfg_trp = CW'(trp);
            do_reset();
            issue(1, 3);
            idle(3);
            issue(5, 3);
            if (rep == 1) issue(5, 3);
            watch(3, 10);
            check("R6", (rep == 1) ? "act after repeated pre" : "act after pre", fk_act, trp);
         end

      // R9 / R10 violations
      cfg_trp = 3;
      do_reset();
      issue(2, 5);
      check("R9", "viol_valid on bad rd", int'(viol_valid), 1);
      check("R9", "viol_bank",            int'(viol_bank),  5);
      check("R9", "viol_cmd",             int'(viol_cmd),   2);
      check("R9", "bank5 still idle",     int'(ok_act[5]),  1);
      check("R9", "bank5 still closed",   int'(ok_rd[5]),   0);
      idle(1);
      check("R9", "viol one cycle",       int'(viol_valid), 0);
      issue(1, 4);
      issue(1, 4);
      check("R9", "viol on act to open bank", int'(viol_valid), 1);
      check("R9", "viol_cmd act",             int'(viol_cmd),   1);
      check("R9", "viol_bank act",            int'(viol_bank),  4);
      issue(7, 6);
      check("R10", "reserved code 7 flagged", int'(viol_valid), 1);
      check("R10", "reserved code echoed",    int'(viol_cmd),   7);
      check("R10", "bank6 untouched",         int'(ok_act[6]),  1);
      issue(6, 1);
      check("R10", "reserved code 6 flagged", int'(viol_valid), 1);
      issue(0, 0);
      check("R10", "nop not flagged",         int'(viol_valid), 0);
      check("R10", "nop leaves bank0 idle",   int'(ok_act[0]),  1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule